// File: doc/BRIEF.md
# Packed Multi-Branch Priority Resolver

This block settles every conditional branch carried by one wide instruction word in the same cycle the word executes. Compare operations in the word compute a one-bit true/false result from two data operands and write it into a small bank of general-purpose condition registers. Each branch slot in the word names one of those registers through a selector field and carries a target address. The block works out which branch slots are taken and picks the one in the lowest-numbered slot. It then drives the next program counter, a taken flag, the index of the winning slot and the number of operations the fetch path must squash.

Compare results live in addressable registers rather than a single flags word. A result can therefore be tested by several branches across a chain of IF tests. Each branch slot may also test the complement of its register. Compare writes land at the clock edge that ends the word. A branch can therefore only observe results produced by earlier words. Compares in a word that also holds a taken branch still complete.

Top module: `br_resolve`

## Requirements
- R1: While rst_ni is low, every condition register reads 0 on cond_o. With no valid word, taken_o is 0 and squash_o is 0.
- R2: Compare opcode 0 (equal) writes 1 when the operands match and 0 otherwise. Opcode 1 (not-equal) writes the inverse of that.
- R3: Opcode 2 compares the operands as two's-complement numbers and opcode 3 compares them as unsigned numbers. Each writes 1 when operand a is less than operand b.
- R4: A compare write lands at the clock edge ending its word. A branch in that same word reads the value the register held before that edge.
- R5: A branch slot is taken when valid_i is 1, its enable bit is 1, and the selected register XOR its negate bit is 1. The word's next_pc_o is then the target of the winning slot.
- R6: When several slots are taken, the lowest slot index wins. Its index appears on win_slot_o.
- R7: In a valid word where no slot is taken, taken_o is 0 and next_pc_o is pc_i + 1.
- R8: Compares in a word whose branch is taken still write their results.
- R9: When two compares in one word target the same register, the lower compare slot's result is stored.
- R10: When valid_i is 0, compares write nothing, taken_o is 0 and next_pc_o equals pc_i.
- R11: When taken_o is 1, squash_o equals FETCH_LAG * OPS_PER_WORD, which is 16 by default. Otherwise squash_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word executes this cycle |
| pc_i | input | PC_W | Address of the executing word |
| cmp_en_i | input | NUM_CMP | Compare slot enables |
| cmp_op_i | input | 2*NUM_CMP | Compare opcodes, 2 bits per slot |
| cmp_a_i | input | DATA_W*NUM_CMP | First operand per compare slot |
| cmp_b_i | input | DATA_W*NUM_CMP | Second operand per compare slot |
| cmp_dst_i | input | SEL_W*NUM_CMP | Destination condition register per compare slot |
| br_en_i | input | NUM_BR | Branch slot enables |
| br_neg_i | input | NUM_BR | Branch on false when set |
| br_sel_i | input | SEL_W*NUM_BR | Condition register tested per branch slot |
| br_tgt_i | input | PC_W*NUM_BR | Target address per branch slot |
| taken_o | output | 1 | A branch in this word is taken |
| win_slot_o | output | SLOT_W | Index of winning slot (0 when none) |
| next_pc_o | output | PC_W | Address of the next word |
| squash_o | output | SQ_W | Operations to squash after redirect |
| cond_o | output | NUM_COND | Current condition register contents |

## Verification
The hardest case to reach from the ports is a single word in which a compare rewrites the very register that a branch in the same word tests. Old-versus-new visibility and the completion of operations beside a taken branch both hinge on that word. The stimulus first sets a register to a known value in one word. It then issues a word that flips the register while branching on it. The bench checks the branch outcome against the old value and checks cond_o after the edge against the new value. Duplicate destinations and two taken slots are driven the same way, with the bench's own register model predicting the winner.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_NE  = 2'd1,
    CMP_LT  = 2'd2,
    CMP_LTU = 2'd3
  } cmp_op_e;
endpackage

// File: rtl/br_cmp_unit.sv
module br_cmp_unit
  import br_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cmp_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_o
);
  logic eq, lt_s, lt_u;

  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    unique case (op_i)
      CMP_EQ:  res_o = eq;
      CMP_NE:  res_o = ~eq;
      CMP_LT:  res_o = lt_s;
      CMP_LTU: res_o = lt_u;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_cond_bank.sv
module br_cond_bank #(
  parameter int NUM_COND = 8,
  parameter int NUM_CMP  = 2,
  localparam int SEL_W   = $clog2(NUM_COND)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CMP-1:0]       wr_en_i,
  input  logic [NUM_CMP*SEL_W-1:0] wr_idx_i,
  input  logic [NUM_CMP-1:0]       wr_val_i,
  output logic [NUM_COND-1:0]      cond_o
);
  logic [NUM_COND-1:0] cond_q, cond_d;

  // walk high to low so the lowest compare slot has the last word
  always_comb begin
    cond_d = cond_q;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (wr_en_i[i]) cond_d[wr_idx_i[i*SEL_W +: SEL_W]] = wr_val_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_d;
  end

  assign cond_o = cond_q;
endmodule

// File: rtl/br_prio_pick.sv
module br_prio_pick #(
  parameter int NUM_BR = 4,
  parameter int PC_W   = 32,
  localparam int SLOT_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic [NUM_BR-1:0]      hit_i,
  input  logic [NUM_BR*PC_W-1:0] tgt_i,
  output logic                   any_o,
  output logic [SLOT_W-1:0]      idx_o,
  output logic [PC_W-1:0]        tgt_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    tgt_o = '0;
    for (int i = NUM_BR - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = SLOT_W'(i);
        tgt_o = tgt_i[i*PC_W +: PC_W];
      end
    end
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int NUM_BR       = 4,
  parameter int NUM_CMP      = 2,
  parameter int NUM_COND     = 8,
  parameter int DATA_W       = 32,
  parameter int PC_W         = 32,
  parameter int FETCH_LAG    = 2,
  parameter int OPS_PER_WORD = 8,
  localparam int SEL_W  = $clog2(NUM_COND),
  localparam int SLOT_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1,
  localparam int SQ_N   = FETCH_LAG * OPS_PER_WORD,
  localparam int SQ_W   = $clog2(SQ_N + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [PC_W-1:0]            pc_i,
  input  logic [NUM_CMP-1:0]         cmp_en_i,
  input  logic [2*NUM_CMP-1:0]       cmp_op_i,
  input  logic [DATA_W*NUM_CMP-1:0]  cmp_a_i,
  input  logic [DATA_W*NUM_CMP-1:0]  cmp_b_i,
  input  logic [SEL_W*NUM_CMP-1:0]   cmp_dst_i,
  input  logic [NUM_BR-1:0]          br_en_i,
  input  logic [NUM_BR-1:0]          br_neg_i,
  input  logic [SEL_W*NUM_BR-1:0]    br_sel_i,
  input  logic [PC_W*NUM_BR-1:0]     br_tgt_i,
  output logic                       taken_o,
  output logic [SLOT_W-1:0]          win_slot_o,
  output logic [PC_W-1:0]            next_pc_o,
  output logic [SQ_W-1:0]            squash_o,
  output logic [NUM_COND-1:0]        cond_o
);
  logic [NUM_CMP-1:0]  cmp_res;
  logic [NUM_CMP-1:0]  cmp_wr;
  logic [NUM_BR-1:0]   br_hit;
  logic [NUM_COND-1:0] cond;
  logic                any_hit;
  logic [SLOT_W-1:0]   win_idx;
  logic [PC_W-1:0]     win_tgt;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    br_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
      .op_i (cmp_op_e'(cmp_op_i[c*2 +: 2])),
      .a_i  (cmp_a_i[c*DATA_W +: DATA_W]),
      .b_i  (cmp_b_i[c*DATA_W +: DATA_W]),
      .res_o(cmp_res[c])
    );
    assign cmp_wr[c] = valid_i & cmp_en_i[c];
  end

  br_cond_bank #(.NUM_COND(NUM_COND), .NUM_CMP(NUM_CMP)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cmp_wr),
    .wr_idx_i(cmp_dst_i),
    .wr_val_i(cmp_res),
    .cond_o  (cond)
  );

  // branches see the bank before this word's compare writes
  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    assign br_hit[b] = valid_i & br_en_i[b] &
                       (cond[br_sel_i[b*SEL_W +: SEL_W]] ^ br_neg_i[b]);
  end

  br_prio_pick #(.NUM_BR(NUM_BR), .PC_W(PC_W)) u_pick (
    .hit_i(br_hit),
    .tgt_i(br_tgt_i),
    .any_o(any_hit),
    .idx_o(win_idx),
    .tgt_o(win_tgt)
  );

  always_comb begin
    taken_o    = any_hit;
    win_slot_o = win_idx;
    squash_o   = any_hit ? SQ_W'(SQ_N) : '0;
    if (!valid_i)     next_pc_o = pc_i;
    else if (any_hit) next_pc_o = win_tgt;
    else              next_pc_o = pc_i + PC_W'(1);
  end

  assign cond_o = cond;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int NUM_BR       = 4,
  parameter int NUM_CMP      = 2,
  parameter int NUM_COND     = 8,
  parameter int DATA_W       = 32,
  parameter int PC_W         = 32,
  parameter int FETCH_LAG    = 2,
  parameter int OPS_PER_WORD = 8,
  localparam int SEL_W  = $clog2(NUM_COND),
  localparam int SLOT_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1,
  localparam int SQ_N   = FETCH_LAG * OPS_PER_WORD,
  localparam int SQ_W   = $clog2(SQ_N + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic [PC_W-1:0]            pc_i,
  input logic [NUM_CMP-1:0]         cmp_en_i,
  input logic [2*NUM_CMP-1:0]       cmp_op_i,
  input logic [DATA_W*NUM_CMP-1:0]  cmp_a_i,
  input logic [DATA_W*NUM_CMP-1:0]  cmp_b_i,
  input logic [SEL_W*NUM_CMP-1:0]   cmp_dst_i,
  input logic [NUM_BR-1:0]          br_en_i,
  input logic [NUM_BR-1:0]          br_neg_i,
  input logic [SEL_W*NUM_BR-1:0]    br_sel_i,
  input logic [PC_W*NUM_BR-1:0]     br_tgt_i,
  input logic                       taken_o,
  input logic [SLOT_W-1:0]          win_slot_o,
  input logic [PC_W-1:0]            next_pc_o,
  input logic [SQ_W-1:0]            squash_o,
  input logic [NUM_COND-1:0]        cond_o
);
  // R5
  taken_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (valid_i && br_en_i[win_slot_o] &&
                 next_pc_o == br_tgt_i[win_slot_o*PC_W +: PC_W]));

  // R7
  fall_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !taken_o) |-> (next_pc_o == pc_i + PC_W'(1)));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cond_o));

  // R10
  idle_no_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!taken_o && next_pc_o == pc_i));

  // R11
  squash_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o == (taken_o ? SQ_W'(SQ_N) : SQ_W'(0)));

  // R2
  eq_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmp_en_i[0] && cmp_op_i[1:0] == 2'd0) |=>
      (cond_o[$past(cmp_dst_i[SEL_W-1:0])] ==
       ($past(cmp_a_i[DATA_W-1:0]) == $past(cmp_b_i[DATA_W-1:0]))));
endmodule

bind br_resolve br_resolve_chk #(
  .NUM_BR(NUM_BR), .NUM_CMP(NUM_CMP), .NUM_COND(NUM_COND), .DATA_W(DATA_W),
  .PC_W(PC_W), .FETCH_LAG(FETCH_LAG), .OPS_PER_WORD(OPS_PER_WORD)
) u_chk (.*);

// File: tb/tb_br_resolve.sv
module tb_br_resolve;
  localparam int NB = 4, NC = 2, NR = 8, DW = 32, PW = 32, SW = 3, SLW = 2;
  localparam int SQ = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [PW-1:0]    pc_i = '0;
  logic [NC-1:0]    cmp_en_i = '0;
  logic [2*NC-1:0]  cmp_op_i = '0;
  logic [DW*NC-1:0] cmp_a_i = '0, cmp_b_i = '0;
  logic [SW*NC-1:0] cmp_dst_i = '0;
  logic [NB-1:0]    br_en_i = '0, br_neg_i = '0;
  logic [SW*NB-1:0] br_sel_i = '0;
  logic [PW*NB-1:0] br_tgt_i = '0;
  logic             taken_o;
  logic [SLW-1:0]   win_slot_o;
  logic [PW-1:0]    next_pc_o;
  logic [4:0]       squash_o;
  logic [NR-1:0]    cond_o;

  br_resolve dut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [NR-1:0] mcond = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_word();
    valid_i = 1'b0; cmp_en_i = '0; br_en_i = '0; br_neg_i = '0;
    cmp_op_i = '0; cmp_a_i = '0; cmp_b_i = '0; cmp_dst_i = '0;
    br_sel_i = '0; br_tgt_i = '0;
  endtask

  task automatic set_cmp(input int s, input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [2:0] dst);
    cmp_en_i[s] = 1'b1; cmp_op_i[s*2 +: 2] = op;
    cmp_a_i[s*DW +: DW] = a; cmp_b_i[s*DW +: DW] = b; cmp_dst_i[s*SW +: SW] = dst;
  endtask

  task automatic set_br(input int s, input logic [2:0] sel, input logic neg,
                        input logic [31:0] tgt);
    br_en_i[s] = 1'b1; br_neg_i[s] = neg;
    br_sel_i[s*SW +: SW] = sel; br_tgt_i[s*PW +: PW] = tgt;
  endtask

  function automatic logic cmp_model(input logic [1:0] op, input logic [31:0] a,
                                     input logic [31:0] b);
    case (op)
      2'd0: return a == b;
      2'd1: return a != b;
      2'd2: return $signed(a) < $signed(b);
      default: return a < b;
    endcase
  endfunction

  // inputs already driven after a negedge: check outputs, take the edge, check bank
  task automatic run_word(input string req);
    logic       et;
    logic [1:0] es;
    logic [31:0] ep;
    et = 1'b0; es = '0; ep = valid_i ? pc_i + 1 : pc_i;
    for (int i = 0; i < NB; i++)
      if (!et && valid_i && br_en_i[i] && (mcond[br_sel_i[i*SW +: SW]] ^ br_neg_i[i])) begin
        et = 1'b1; es = 2'(i); ep = br_tgt_i[i*PW +: PW];
      end
    #1;
    chk({req, " taken"}, 64'(taken_o), 64'(et));
    chk({req, " next_pc"}, 64'(next_pc_o), 64'(ep));
    if (et) chk({req, " slot"}, 64'(win_slot_o), 64'(es));
    chk({req, " R11 squash"}, 64'(squash_o), et ? 64'(SQ) : 64'd0);
    for (int i = NC - 1; i >= 0; i--)
      if (valid_i && cmp_en_i[i])
        mcond[cmp_dst_i[i*SW +: SW]] = cmp_model(cmp_op_i[i*2 +: 2],
          cmp_a_i[i*DW +: DW], cmp_b_i[i*DW +: DW]);
    @(negedge clk_i);
    chk({req, " cond"}, 64'(cond_o), 64'(mcond));
    clear_word();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 cond at reset", 64'(cond_o), 64'd0);
    chk("R1 taken at reset", 64'(taken_o), 64'd0);
    chk("R1 squash at reset", 64'(squash_o), 64'd0);
  endtask

  task automatic t_cmp_ops();
    valid_i = 1; pc_i = 32'h100;
    set_cmp(0, 2'd0, 32'h55, 32'h55, 3'd1);
    set_cmp(1, 2'd1, 32'h7, 32'h7, 3'd4);
    run_word("R2 eq/ne");
    valid_i = 1; pc_i = 32'h101;
    set_cmp(0, 2'd2, 32'hFFFF_FFFF, 32'h1, 3'd2);
    set_cmp(1, 2'd3, 32'hFFFF_FFFF, 32'h1, 3'd3);
    run_word("R3 lt signed/unsigned");
    chk("R3 signed bit", 64'(cond_o[2]), 64'd1);
    chk("R3 unsigned bit", 64'(cond_o[3]), 64'd0);
    chk("R2 eq bit", 64'(cond_o[1]), 64'd1);
  endtask

  task automatic t_single();
    valid_i = 1; pc_i = 32'h200;
    set_br(2, 3'd1, 1'b0, 32'hABC);
    run_word("R5 single branch");
  endtask

  task automatic t_priority();
    valid_i = 1; pc_i = 32'h300;
    set_br(3, 3'd2, 1'b0, 32'h333);
    set_br(1, 3'd1, 1'b0, 32'h111);
    set_br(0, 3'd0, 1'b0, 32'h000);
    run_word("R6 priority");
  endtask

  task automatic t_none();
    valid_i = 1; pc_i = 32'h400;
    set_br(0, 3'd0, 1'b0, 32'h9);
    set_br(3, 3'd3, 1'b0, 32'h9);
    run_word("R7 fall through");
  endtask

  task automatic t_negate();
    valid_i = 1; pc_i = 32'h500;
    set_br(3, 3'd0, 1'b1, 32'h5A5);
    run_word("R5 negated test");
  endtask

  task automatic t_same_word();
    valid_i = 1; pc_i = 32'h600;
    set_cmp(0, 2'd0, 32'h1, 32'h1, 3'd6);
    set_br(0, 3'd6, 1'b0, 32'h66);
    run_word("R4 old value seen");
    valid_i = 1; pc_i = 32'h610;
    set_cmp(1, 2'd1, 32'h1, 32'h1, 3'd6);
    set_br(1, 3'd6, 1'b0, 32'h77);
    run_word("R8 compare beside taken branch");
    chk("R8 reg cleared", 64'(cond_o[6]), 64'd0);
  endtask

  task automatic t_dup();
    valid_i = 1; pc_i = 32'h700;
    set_cmp(0, 2'd0, 32'h3, 32'h3, 3'd5);
    set_cmp(1, 2'd1, 32'h3, 32'h3, 3'd5);
    run_word("R9 duplicate dest");
    chk("R9 slot0 value", 64'(cond_o[5]), 64'd1);
    valid_i = 1; pc_i = 32'h701;
    set_cmp(0, 2'd1, 32'h3, 32'h3, 3'd5);
    set_cmp(1, 2'd0, 32'h3, 32'h3, 3'd5);
    run_word("R9 duplicate dest swapped");
  endtask

  task automatic t_invalid();
    valid_i = 0; pc_i = 32'h800;
    set_cmp(0, 2'd1, 32'h1, 32'h2, 3'd7);
    set_br(0, 3'd1, 1'b0, 32'h88);
    run_word("R10 idle word");
    chk("R10 reg untouched", 64'(cond_o[7]), 64'd0);
  endtask

  task automatic t_reset_mid();
    rst_ni = 0;
    #2;
    chk("R1 cleared by reset", 64'(cond_o), 64'd0);
    mcond = '0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_word();
    @(negedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_cmp_ops();
    t_single();
    t_priority();
    t_none();
    t_negate();
    t_same_word();
    t_dup();
    t_invalid();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule